// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block sits on an 8-bit I/O bus and exposes a small bank of chipset control registers through two addresses. A write to the index address selects a register number. A read or write at the data address then reaches the selected register. Each register keeps only the bits its write mask allows, and the masks depend on a variant input that selects the basic or the extended register profile.

Two registers have side effects. The clock-control register drives an ISA bus clock-source selection, and in the extended profile it also drives an NVRAM bank select. Index 85h has no storage of its own. An access there becomes a request/acknowledge transaction to an external RTC index port. The bus access stalls through `io_ready_o` until that port acknowledges.

Bus protocol: the host raises `io_rd_i` or `io_wr_i` together with `io_addr_i` and the data, and holds them until it sees `io_ready_o` high. The access completes on that clock edge. Register reads are combinational while `io_rd_i` is high. Register writes become visible after the completing edge. The variant input is static and may only change while the block is in reset.

Top module: `idx_cfg_port`

## Requirements
- R1: A write with `io_addr_i`=0 stores the index byte, and a read with `io_addr_i`=0 returns it. A data access (`io_addr_i`=1) uses the stored index.
- R2: Bits 7:6 of a data write to index 80h set `isa_clk_sel_o` as follows: 0 gives 2'd0 (fixed 7.159091 MHz source), 1 gives 2'd1 (PCI clock / 4), and 2 gives 2'd2 (PCI clock / 3). The value 3 leaves `isa_clk_sel_o` unchanged.
- R3: After reset, `isa_clk_sel_o` is 2'd0, `nvram_bank_o` is 0, the index is 00h, and every register reads 00h.
- R4: With `ext_i`=0, index 80h stores the written value ANDed with E7h and index 81h stores it ANDed with F4h. `nvram_bank_o` stays 0.
- R5: With `ext_i`=1, index 80h stores all eight bits and `nvram_bank_o` equals its bit 3. Index 81h stores the written value ANDed with F6h.
- R6: With `ext_i`=1, index 82h stores all bits and index 83h keeps only bits 1:0. With `ext_i`=0, both indices read 00h after any write.
- R7: Indices 84h, 88h, 89h, 8Ah and 8Bh store all eight bits in both variants.
- R8: Indices that are not implemented (00h–7Fh, 86h, 87h, 8Ch–FFh) read 00h, and writes to them change nothing.
- R9: A data write at index 85h raises `rtc_req_o` with `rtc_we_o`=1 and `rtc_wdata_o` equal to the bus data. `rtc_req_o` stays high until `rtc_ack_i`. `io_ready_o` goes high one cycle after the acknowledge.
- R10: A data read at index 85h holds `io_ready_o` low until the RTC acknowledge arrives, then returns the `rtc_rdata_i` value captured with the acknowledge.
- R11: No access other than a data access at index 85h raises `rtc_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_i | input | 1 | Register profile: 0 basic, 1 extended (static) |
| io_rd_i | input | 1 | Bus read strobe, held until ready |
| io_wr_i | input | 1 | Bus write strobe, held until ready |
| io_addr_i | input | 1 | 0 selects the index address, 1 selects the data address |
| io_wdata_i | input | 8 | Bus write data |
| io_rdata_o | output | 8 | Bus read data |
| io_ready_o | output | 1 | Access completes on the edge where this is high |
| isa_clk_sel_o | output | 2 | ISA clock source: 0 fixed, 1 PCI/4, 2 PCI/3 |
| nvram_bank_o | output | 1 | NVRAM bank select |
| rtc_req_o | output | 1 | RTC index port request |
| rtc_we_o | output | 1 | RTC request direction, 1 for a write |
| rtc_wdata_o | output | 8 | RTC write data |
| rtc_rdata_i | input | 8 | RTC read data, valid with the acknowledge |
| rtc_ack_i | input | 1 | RTC acknowledge |

## Verification
The bench writes all-ones and mixed patterns under both profiles. A swapped or wrong mask shows up as a read-back that keeps bits it should drop, and a basic profile that stores 82h or 83h returns nonzero data there. It writes field value 3 after each of the other clock codes, so a decoder that treats 3 as a real source changes `isa_clk_sel_o` when it must hold. At index 85h the bench counts stall cycles against the RTC model's acknowledge delay and checks the captured read data and the forwarded write byte. A bridge that completes early reports too few stall cycles or stale data. A decoder that forwards other indices raises the model's request count.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned NREG     = 12;
  localparam logic [7:0]  REG_BASE = 8'h80;
  localparam logic [7:0]  PT_IDX   = 8'h85;
  localparam int unsigned OW       = $clog2(NREG);

  typedef enum logic [1:0] {
    CLK_FIXED  = 2'd0,
    CLK_PCIDV4 = 2'd1,
    CLK_PCIDV3 = 2'd2
  } isa_clk_e;

  // write mask per register offset from REG_BASE, per profile
  function automatic logic [DW-1:0] reg_mask(int unsigned off, logic ext);
    case (off)
      0:             reg_mask = ext ? 8'hFF : 8'hE7;
      1:             reg_mask = ext ? 8'hF6 : 8'hF4;
      2:             reg_mask = ext ? 8'hFF : 8'h00;
      3:             reg_mask = ext ? 8'h03 : 8'h00;
      4, 8, 9, 10, 11: reg_mask = 8'hFF;
      default:       reg_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/idx_cfg_regbank.sv
module idx_cfg_regbank
  import idx_cfg_pkg::*;
#(
  parameter int unsigned N  = NREG,
  parameter int unsigned AW = OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_i,
  input  logic          wr_en_i,
  input  logic          hit_i,
  input  logic [AW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_val_o,
  output logic [DW-1:0] ctl_o
);
  logic [DW-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [AW-1:0] ME = AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q[g] <= '0;
      else if (wr_en_i && hit_i && off_i == ME)   q[g] <= wdata_i & reg_mask(g, ext_i);
    end
  end

  always_comb begin
    rd_val_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_i && off_i == AW'(i)) rd_val_o = q[i];
  end

  assign ctl_o = q[0];

  p_basic_ctl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_i |-> q[0][4:3] == 2'b00);
  p_basic_ext_regs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_i |-> (q[2] == '0 && q[3] == '0));
  p_narrow_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[3][7:2] == '0);
endmodule

// File: rtl/idx_cfg_clksel.sv
module idx_cfg_clksel
  import idx_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] field_i,
  output isa_clk_e   sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= CLK_FIXED;
    else if (load_i) begin
      case (field_i)
        2'd0:    sel_o <= CLK_FIXED;
        2'd1:    sel_o <= CLK_PCIDV4;
        2'd2:    sel_o <= CLK_PCIDV3;
        default: sel_o <= sel_o; // code 3 keeps the current source
      endcase
    end
  end

  p_code3_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && field_i == 2'b11) |=> $stable(sel_o));
  p_load_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && field_i != 2'b11) |=> sel_o == isa_clk_e'($past(field_i)));
endmodule

// File: rtl/idx_cfg_rtc_bridge.sv
module idx_cfg_rtc_bridge
  import idx_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  typedef enum logic [1:0] {B_IDLE, B_BUSY, B_DONE} bst_e;
  bst_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      rdata_o <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (start_i) st_q <= B_BUSY;
        B_BUSY: if (ack_i) begin
          st_q    <= B_DONE;
          rdata_o <= rdata_i;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == B_BUSY);
  assign done_o = (st_q == B_DONE);

  p_req_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  p_done_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ack_i));
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import idx_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_i,
  input  logic          io_rd_i,
  input  logic          io_wr_i,
  input  logic          io_addr_i,
  input  logic [DW-1:0] io_wdata_i,
  output logic [DW-1:0] io_rdata_o,
  output logic          io_ready_o,
  output logic [1:0]    isa_clk_sel_o,
  output logic          nvram_bank_o,
  output logic          rtc_req_o,
  output logic          rtc_we_o,
  output logic [DW-1:0] rtc_wdata_o,
  input  logic [DW-1:0] rtc_rdata_i,
  input  logic          rtc_ack_i
);
  logic [DW-1:0] index_q;
  logic          hit, pt_acc, pt_done, reg_wr, ctl_load;
  logic [OW-1:0] off;
  logic [DW-1:0] bank_rd, ctl, pt_rdata;
  isa_clk_e      clk_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    index_q <= '0;
    else if (io_wr_i && !io_addr_i) index_q <= io_wdata_i;
  end

  assign hit    = (index_q >= REG_BASE) && (index_q < REG_BASE + DW'(NREG));
  assign off    = OW'(index_q - REG_BASE);
  assign pt_acc = (io_rd_i || io_wr_i) && io_addr_i && (index_q == PT_IDX);
  assign reg_wr = io_wr_i && io_addr_i && !pt_acc;
  assign ctl_load = reg_wr && (index_q == REG_BASE);

  idx_cfg_regbank u_bank (
    .clk_i, .rst_ni, .ext_i,
    .wr_en_i (reg_wr),
    .hit_i   (hit),
    .off_i   (off),
    .wdata_i (io_wdata_i),
    .rd_val_o(bank_rd),
    .ctl_o   (ctl)
  );

  idx_cfg_clksel u_clk (
    .clk_i, .rst_ni,
    .load_i (ctl_load),
    .field_i(io_wdata_i[7:6]),
    .sel_o  (clk_sel)
  );

  idx_cfg_rtc_bridge u_rtc (
    .clk_i, .rst_ni,
    .start_i(pt_acc),
    .ack_i  (rtc_ack_i),
    .rdata_i(rtc_rdata_i),
    .req_o  (rtc_req_o),
    .done_o (pt_done),
    .rdata_o(pt_rdata)
  );

  assign rtc_we_o      = io_wr_i;
  assign rtc_wdata_o   = io_wdata_i;
  assign io_ready_o    = pt_acc ? pt_done : 1'b1;
  assign isa_clk_sel_o = clk_sel;
  assign nvram_bank_o  = ext_i & ctl[3];

  always_comb begin
    if (!io_addr_i)              io_rdata_o = index_q;
    else if (index_q == PT_IDX)  io_rdata_o = pt_rdata;
    else                         io_rdata_o = bank_rd;
  end

  p_no_stray_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_req_o |-> index_q == PT_IDX);
  p_stall_on_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rtc_req_o) |-> !io_ready_o);
  p_idx_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && !io_addr_i) |=> index_q == $past(io_wdata_i));
  p_bank_basic_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_i |-> !nvram_bank_o);
endmodule

// File: tb/tb_idx_cfg_port.sv
`timescale 1ns/1ps
module tb_idx_cfg_port;
  localparam int ACK_DLY = 4;

  logic       clk = 1'b0, rst_n = 1'b0, ext = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata, rtc_wdata, rtc_rdata = 8'h6E;
  logic       ready, bank, req, we, ack = 1'b0;
  logic [1:0] csel;

  always #2.5 clk = ~clk;

  idx_cfg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_i(ext),
    .io_rd_i(rd), .io_wr_i(wr), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .io_ready_o(ready),
    .isa_clk_sel_o(csel), .nvram_bank_o(bank),
    .rtc_req_o(req), .rtc_we_o(we), .rtc_wdata_o(rtc_wdata),
    .rtc_rdata_i(rtc_rdata), .rtc_ack_i(ack)
  );

  // RTC model
  int         dly_cnt = 0, req_cnt = 0;
  logic       req_d = 1'b0;
  logic [7:0] rtc_last_w = '0;
  logic       rtc_last_we = 1'b0;
  always @(posedge clk) begin
    ack   <= 1'b0;
    req_d <= req;
    if (req && !req_d) begin
      req_cnt++;
      rtc_last_w  <= rtc_wdata;
      rtc_last_we <= we;
    end
    if (req && !ack) begin
      if (dly_cnt == ACK_DLY - 1) begin ack <= 1'b1; dly_cnt = 0; end
      else dly_cnt++;
    end
  end

  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // scoreboard for bus reads
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         stall;
  always @(negedge clk) begin
    if (rd && ready && rst_n) begin
      if (exp_q.size() == 0) check("SB_EMPTY", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic bus(input logic is_rd, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    rd = is_rd; wr = !is_rd; addr = a; wdata = d; stall = 0;
    @(negedge clk);
    while (!ready) begin stall++; @(negedge clk); end
    @(posedge clk); #1;
    rd = 0; wr = 0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    bus(0, 0, idx);
    bus(0, 1, d);
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string t);
    bus(0, 0, idx);
    exp_q.push_back(exp); tag_q.push_back(t);
    bus(1, 1, 8'h00);
  endtask

  task automatic do_reset(input logic variant);
    @(posedge clk); #1;
    rst_n = 0; ext = variant;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  int rc;
  initial begin
    do_reset(0);
    @(negedge clk);
    check("R3_clk", csel, 0);
    check("R3_bank", bank, 0);
    exp_q.push_back(8'h00); tag_q.push_back("R3_index");
    bus(1, 0, 8'h00);
    rd_reg(8'h80, 8'h00, "R3_reg80");
    rd_reg(8'h8B, 8'h00, "R3_reg8B");

    // R1 index
    bus(0, 0, 8'h3C);
    exp_q.push_back(8'h3C); tag_q.push_back("R1_index");
    bus(1, 0, 8'h00);

    // basic profile
    rc = req_cnt;
    wr_reg(8'h80, 8'hFF);
    rd_reg(8'h80, 8'hE7, "R4_mask80");
    @(negedge clk); check("R2_code3_hold", csel, 0);
    check("R4_bank", bank, 0);
    wr_reg(8'h80, 8'h5A);
    rd_reg(8'h80, 8'h42, "R4_mask80b");
    @(negedge clk); check("R2_div4", csel, 1);
    wr_reg(8'h80, 8'hC0);
    @(negedge clk); check("R2_code3_after_div4", csel, 1);
    wr_reg(8'h80, 8'h88);
    @(negedge clk); check("R2_div3", csel, 2);
    check("R4_bank_bit3", bank, 0);
    wr_reg(8'h81, 8'hFF);
    rd_reg(8'h81, 8'hF4, "R4_mask81");
    wr_reg(8'h82, 8'hFF);
    rd_reg(8'h82, 8'h00, "R6_basic82");
    wr_reg(8'h83, 8'hFF);
    rd_reg(8'h83, 8'h00, "R6_basic83");
    wr_reg(8'h84, 8'hA5);
    wr_reg(8'h88, 8'h11);
    wr_reg(8'h89, 8'h22);
    wr_reg(8'h8A, 8'h33);
    wr_reg(8'h8B, 8'h44);
    rd_reg(8'h84, 8'hA5, "R7_84");
    rd_reg(8'h88, 8'h11, "R7_88");
    rd_reg(8'h89, 8'h22, "R7_89");
    rd_reg(8'h8A, 8'h33, "R7_8A");
    rd_reg(8'h8B, 8'h44, "R7_8B");
    wr_reg(8'h86, 8'hFF);
    rd_reg(8'h86, 8'h00, "R8_86");
    wr_reg(8'h87, 8'h5C);
    rd_reg(8'h87, 8'h00, "R8_87");
    wr_reg(8'h8C, 8'hFF);
    rd_reg(8'h8C, 8'h00, "R8_8C");
    wr_reg(8'h00, 8'hFF);
    rd_reg(8'h00, 8'h00, "R8_00");
    rd_reg(8'h84, 8'hA5, "R8_neighbor84");
    rd_reg(8'h88, 8'h11, "R8_neighbor88");
    @(negedge clk); check("R2_unaffected", csel, 2);
    check("R11_no_req", req_cnt, rc);

    // extended profile
    do_reset(1);
    @(negedge clk);
    check("R3_ext_clk", csel, 0);
    check("R3_ext_bank", bank, 0);
    rd_reg(8'h84, 8'h00, "R3_ext_reg84");
    wr_reg(8'h80, 8'h08);
    rd_reg(8'h80, 8'h08, "R5_full80");
    @(negedge clk); check("R5_bank1", bank, 1);
    check("R2_fixed", csel, 0);
    wr_reg(8'h80, 8'h48);
    @(negedge clk); check("R2_ext_div4", csel, 1);
    wr_reg(8'h80, 8'hC7);
    rd_reg(8'h80, 8'hC7, "R5_full80b");
    @(negedge clk); check("R2_ext_code3", csel, 1);
    check("R5_bank0", bank, 0);
    wr_reg(8'h81, 8'hFF);
    rd_reg(8'h81, 8'hF6, "R5_mask81");
    wr_reg(8'h82, 8'hFF);
    rd_reg(8'h82, 8'hFF, "R6_ext82");
    wr_reg(8'h83, 8'hFF);
    rd_reg(8'h83, 8'h03, "R6_ext83");
    wr_reg(8'h89, 8'h9C);
    rd_reg(8'h89, 8'h9C, "R7_ext89");

    // RTC pass-through
    rc = req_cnt;
    bus(0, 0, 8'h85);
    bus(0, 1, 8'h0D);
    check("R9_req_count", req_cnt, rc + 1);
    check("R9_wdata", rtc_last_w, 8'h0D);
    check("R9_we", rtc_last_we, 1);
    check("R9_stall", int'(stall >= ACK_DLY), 1);
    rtc_rdata = 8'h6E;
    exp_q.push_back(8'h6E); tag_q.push_back("R10_rdata");
    bus(1, 1, 8'h00);
    check("R10_stall", int'(stall >= ACK_DLY), 1);
    check("R10_we", rtc_last_we, 0);
    check("R10_req_count", req_cnt, rc + 2);
    rc = req_cnt;
    rd_reg(8'h84, 8'h00, "R11_other_read");
    wr_reg(8'h86, 8'h85);
    @(negedge clk); check("R11_no_req_ext", req_cnt, rc);
    check("R8_index_ok", exp_q.size(), 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule